// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage, in-order pipeline. It decides where each of the two ALU operands comes from. The choices are the value read from the register file, the result held in the execute/memory register, or the result held in the memory/writeback register. To decide, it compares the two source register numbers of the instruction now in execute with the destination register numbers and write enables of the two older instructions further down the pipe.

The block is purely combinational. It drives a 2-bit select for each operand. It also applies that select to the three candidate data values, so the ALU receives ready-to-use operands. Each operand is resolved by its own lane, so the two operands can bypass from the same stage or from different stages in one cycle. Register zero is never treated as a real producer. When both older instructions write the wanted register, the younger one, in execute/memory, supplies the value.

Top module: `operand_bypass`

## Requirements
- R1: Each select takes one of three codes: 2'b00 picks the register-file value, 2'b10 picks the execute/memory result, and 2'b01 picks the memory/writeback result. The code 2'b11 never appears.
- R2: When `xm_wen` is 1, `xm_dst` is non-zero and `xm_dst` equals an operand's source number, that operand's select is 2'b10.
- R3: When `mw_wen` is 1, `mw_dst` is non-zero and `mw_dst` equals an operand's source number, and R2 does not apply to that operand, its select is 2'b01.
- R4: When both older stages qualify for the same operand, the execute/memory stage wins and the select is 2'b10.
- R5: A stage whose write enable is 0 never supplies a bypass, even when its destination number matches.
- R6: A destination number of zero never supplies a bypass, even when the source number is also zero and the write enable is 1.
- R7: Operand A is compared only against `src_a`, and operand B only against `src_b`. The two selects are independent and may both be non-zero in the same cycle.
- R8: `opnd_a` and `opnd_b` equal the data value chosen by their select, in the same cycle.
- R9: In a chain of three instructions that each read and write the same register, every instruction receives the newest value of that register.
- R10: When no stage qualifies, the select is 2'b00 and the operand equals its register-file value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 5 | First source register number of the instruction in execute |
| src_b | input | 5 | Second source register number of the instruction in execute |
| xm_dst | input | 5 | Destination register number in the execute/memory register |
| xm_wen | input | 1 | Register-write flag in the execute/memory register |
| mw_dst | input | 5 | Destination register number in the memory/writeback register |
| mw_wen | input | 1 | Register-write flag in the memory/writeback register |
| rf_a | input | 32 | Register-file value for operand A |
| rf_b | input | 32 | Register-file value for operand B |
| xm_data | input | 32 | Result held in the execute/memory register |
| mw_data | input | 32 | Result held in the memory/writeback register |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B |

## Verification
Every output of this block settles in the same cycle as its inputs, so each result is due zero clock cycles after a stimulus. The driver applies one input set on each rising bench edge and queues the expected selects and operands for it. The monitor pops the queue on the following falling edge, half a period later and before the next input set, so each comparison sees exactly the stimulus it was queued with. Directed cases cover the priority, zero-register, write-enable and accumulation-chain situations. Randomised cases draw register numbers from a small range so that matches between stages are frequent.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_MW = 2'b01,
    SEL_XM = 2'b10
  } sel_e;

  // a producer qualifies when it writes, is not register zero, and matches
  function automatic logic producer_hit(input logic wen,
                                        input logic [4:0] dst,
                                        input logic [4:0] src);
    return wen && (dst != 5'd0) && (dst == src);
  endfunction

  // the younger stage (execute/memory) outranks the older one
  function automatic sel_e pick_source(input logic xm_hit, input logic mw_hit);
    if (xm_hit)      return SEL_XM;
    else if (mw_hit) return SEL_MW;
    else             return SEL_RF;
  endfunction
endpackage

// File: rtl/bypass_lane.sv
module bypass_lane
  import bypass_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] xm_dst,
  input  logic             xm_wen,
  input  logic [REG_W-1:0] mw_dst,
  input  logic             mw_wen,
  output sel_e             sel
);
  logic xm_hit;
  logic mw_hit;

  assign xm_hit = producer_hit(xm_wen, xm_dst, src);
  assign mw_hit = producer_hit(mw_wen, mw_dst, src);
  assign sel    = pick_source(xm_hit, mw_hit);

  always_comb begin
    // R1
    code_legal_chk: assert (sel != 2'b11);
    // R5
    if (!xm_wen) xm_wen_gate_chk: assert (sel != SEL_XM);
    if (!mw_wen) mw_wen_gate_chk: assert (sel != SEL_MW);
    // R6
    if (xm_dst == '0) xm_zero_chk: assert (sel != SEL_XM);
    if (mw_dst == '0) mw_zero_chk: assert (sel != SEL_MW);
    // R4
    if (xm_hit && mw_hit) newest_wins_chk: assert (sel == SEL_XM);
  end
endmodule

// File: rtl/operand_mux.sv
module operand_mux
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  sel_e              sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] xm_val,
  input  logic [DATA_W-1:0] mw_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (sel)
      SEL_XM:  opnd = xm_val;
      SEL_MW:  opnd = mw_val;
      default: opnd = rf_val;
    endcase
  end

  always_comb begin
    // R8
    if (sel == SEL_RF) mux_rf_chk: assert (opnd == rf_val);
    if (sel == SEL_XM) mux_xm_chk: assert (opnd == xm_val);
    if (sel == SEL_MW) mux_mw_chk: assert (opnd == mw_val);
  end
endmodule

// File: rtl/operand_bypass.sv
module operand_bypass
  import bypass_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  input  logic [REG_W-1:0]  xm_dst,
  input  logic              xm_wen,
  input  logic [REG_W-1:0]  mw_dst,
  input  logic              mw_wen,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] xm_data,
  input  logic [DATA_W-1:0] mw_data,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int N_OPND = 2;

  logic [REG_W-1:0]  lane_src [N_OPND];
  logic [DATA_W-1:0] lane_rf  [N_OPND];
  logic [DATA_W-1:0] lane_out [N_OPND];
  sel_e              lane_sel [N_OPND];

  assign lane_src[0] = src_a;
  assign lane_src[1] = src_b;
  assign lane_rf[0]  = rf_a;
  assign lane_rf[1]  = rf_b;

  // R7: one independent lane per operand
  for (genvar g = 0; g < N_OPND; g++) begin : g_lane
    bypass_lane #(.REG_W(REG_W)) u_lane (
      .src    (lane_src[g]),
      .xm_dst (xm_dst),
      .xm_wen (xm_wen),
      .mw_dst (mw_dst),
      .mw_wen (mw_wen),
      .sel    (lane_sel[g])
    );
    operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel    (lane_sel[g]),
      .rf_val (lane_rf[g]),
      .xm_val (xm_data),
      .mw_val (mw_data),
      .opnd   (lane_out[g])
    );
  end

  assign sel_a  = lane_sel[0];
  assign sel_b  = lane_sel[1];
  assign opnd_a = lane_out[0];
  assign opnd_b = lane_out[1];

  always_comb begin
    // R7
    if (src_a == src_b) same_src_chk: assert (sel_a == sel_b);
  end
endmodule

// File: tb/operand_bypass_test.sv
module operand_bypass_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0]  src_a = '0, src_b = '0, xm_dst = '0, mw_dst = '0;
  logic        xm_wen = 1'b0, mw_wen = 1'b0;
  logic [31:0] rf_a = '0, rf_b = '0, xm_data = '0, mw_data = '0;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  operand_bypass uut (
    .src_a(src_a), .src_b(src_b), .xm_dst(xm_dst), .xm_wen(xm_wen),
    .mw_dst(mw_dst), .mw_wen(mw_wen), .rf_a(rf_a), .rf_b(rf_b),
    .xm_data(xm_data), .mw_data(mw_data),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  typedef struct {
    logic [1:0]  ea;
    logic [1:0]  eb;
    logic [31:0] va;
    logic [31:0] vb;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference written from the requirement text, not from the RTL
  function automatic logic [1:0] ref_code(input logic [4:0] s,
      input logic [4:0] xd, input logic xw, input logic [4:0] md, input logic mw);
    logic xq, mq;
    xq = (xd == s) && xw && (xd != 0);
    mq = (md == s) && mw && (md != 0);
    case ({xq, mq})
      2'b10, 2'b11: return 2'b10;
      2'b01:        return 2'b01;
      default:      return 2'b00;
    endcase
  endfunction

  function automatic logic [31:0] ref_val(input logic [1:0] c,
      input logic [31:0] rf, input logic [31:0] x, input logic [31:0] m);
    return (c == 2'b10) ? x : (c == 2'b01) ? m : rf;
  endfunction

  task automatic drive(input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] xd, input logic xw,
                       input logic [4:0] md, input logic mw, input string tag);
    exp_t e;
    @(posedge clk);
    src_a = a; src_b = b; xm_dst = xd; xm_wen = xw; mw_dst = md; mw_wen = mw;
    rf_a = $urandom; rf_b = $urandom; xm_data = $urandom; mw_data = $urandom;
    e.ea  = ref_code(a, xd, xw, md, mw);
    e.eb  = ref_code(b, xd, xw, md, mw);
    e.va  = ref_val(e.ea, rf_a, xm_data, mw_data);
    e.vb  = ref_val(e.eb, rf_b, xm_data, mw_data);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: results are due in the same cycle, sampled half a period later
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp({30'd0, sel_a}, {30'd0, e.ea}, e.tag, "sel_a");
        cmp({30'd0, sel_b}, {30'd0, e.eb}, e.tag, "sel_b");
        cmp(opnd_a, e.va, e.tag, "opnd_a");
        cmp(opnd_b, e.vb, e.tag, "opnd_b");
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, "R10 idle");
    drive(5'd3, 5'd4, 5'd3, 1'b1, 5'd9, 1'b1, "R2 xm to A");
    drive(5'd3, 5'd4, 5'd9, 1'b1, 5'd4, 1'b1, "R3 mw to B");
    drive(5'd6, 5'd6, 5'd6, 1'b1, 5'd6, 1'b1, "R4 both match");
    drive(5'd7, 5'd7, 5'd7, 1'b0, 5'd7, 1'b0, "R5 wen low");
    drive(5'd7, 5'd2, 5'd7, 1'b0, 5'd7, 1'b1, "R5 xm off mw on");
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, "R6 reg zero");
    drive(5'd0, 5'd5, 5'd0, 1'b1, 5'd5, 1'b1, "R6 zero A mw B");
    drive(5'd8, 5'd11, 5'd8, 1'b1, 5'd11, 1'b1, "R7 split sources");
    drive(5'd12, 5'd13, 5'd14, 1'b1, 5'd15, 1'b1, "R10 no match");
    drive(5'd1, 5'd1, 5'd1, 1'b1, 5'd1, 1'b1, "R1 codes");
    // R9: three accumulations into register 1
    drive(5'd1, 5'd2, 5'd20, 1'b1, 5'd21, 1'b1, "R9 step1");
    drive(5'd1, 5'd3, 5'd1, 1'b1, 5'd20, 1'b1, "R9 step2");
    drive(5'd1, 5'd4, 5'd1, 1'b1, 5'd1, 1'b1, "R9 step3");
    // R8 with randomised numbers from a small pool
    for (int i = 0; i < 3000; i++) begin
      drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), "R8 random");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule